// File: doc/BRIEF.md
# AXI4-Lite Register Bridge Across Clock Domains

This block accepts single AXI4-Lite transactions from a processor running on one clock and replays each one as a simple register access on a second, unrelated clock. On the register side a write is a one-cycle write strobe with a word address, data and byte enables. A read is a one-cycle request followed by a wait for the target's read-valid input, which brings the read data back.

Each accepted transaction is captured in CPU-domain registers. A request toggle then travels to the user domain through a two-flop synchronizer. The user domain runs the register access and answers with an acknowledge toggle that travels back the same way. Only after that toggle has arrived does the CPU side raise the B or R response. The captured address, data, byte enables and direction stay frozen while the transaction is in flight. The register side therefore reads them directly with no further synchronization. Only one transaction is in flight at a time.

CPU-side states: `C_IDLE` (waiting for a request), `C_BUSY` (request in flight) and `C_RESP` (response offered). Transitions: *accept* (C_IDLE to C_BUSY on a complete write or a read), *ack* (C_BUSY to C_RESP when the acknowledge toggle matches the request toggle) and *retire* (C_RESP to C_IDLE on BREADY or RREADY). User-side states: `U_IDLE`, `U_WRITE`, `U_RDREQ` and `U_RDWAIT`. Transitions: *launch-write* (U_IDLE to U_WRITE), *launch-read* (U_IDLE to U_RDREQ), *strobe-done* (U_WRITE to U_IDLE), *request-done* (U_RDREQ to U_RDWAIT) and *data-in* (U_RDWAIT to U_IDLE on read-valid).

Top module: `axreg_bridge`

## Requirements
- R1: After either reset, with no AXI valid asserted, all AXI ready and response-valid outputs and both register-side strobes (`reg_wr_en`, `reg_rd_req`) are low.
- R2: `reg_addr` carries bits [AW-1:2] of the accepted AXI byte address, so it is a 32-bit word index. Accepted addresses are word aligned.
- R3: Each write produces exactly one `reg_wr_en` pulse lasting one user-clock cycle. The pulse carries the AXI write data and the 4-bit byte enable unchanged. Enable bit n qualifies data bits 8n+7 down to 8n.
- R4: A write is accepted only when AWVALID and WVALID are both high. AWREADY and WREADY rise together in that cycle, and AWREADY stays low while only the address is offered.
- R5: Each read produces exactly one `reg_rd_req` pulse lasting one user-clock cycle. The data on `reg_rd_data` is taken in the first cycle after the request in which `reg_rd_valid` is high, and is returned as RDATA.
- R6: `reg_addr` holds its value from the read request until `reg_rd_valid` is seen.
- R7: From acceptance until the B or R handshake completes, AWREADY, WREADY and ARREADY are all low.
- R8: BRESP and RRESP are always OKAY (2'b00). BVALID or RVALID rises only after the register-side access has completed.
- R9: A raised BVALID or RVALID stays high, with RDATA stable, until the matching ready is seen.
- R10: When a complete write and a read are offered in the same idle cycle, the write is accepted first and the read waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-domain clock |
| cpu_rst_n | input | 1 | CPU-domain active-low reset |
| s_awaddr | input | AW | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DW | Write data |
| s_wstrb | input | DW/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AW | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DW | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| usr_clk | input | 1 | Register-domain clock |
| usr_rst_n | input | 1 | Register-domain active-low reset |
| reg_addr | output | AW-2 | Register word address |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | DW | Register write data |
| reg_wr_be | output | DW/8 | Register byte enables |
| reg_rd_req | output | 1 | One-cycle read request |
| reg_rd_data | input | DW | Register read data |
| reg_rd_valid | input | 1 | Read data valid from the register target |

## Verification
The bench presents the write address several cycles ahead of the write data. A bridge that accepted AW alone would raise AWREADY early, or would strobe a write carrying stale data. Read latencies from one to four user cycles, together with delayed BREADY and RREADY, probe two failure modes: sampling `reg_rd_data` before read-valid, which returns filler data, and dropping the response before the handshake. Partial and empty byte-enable writes followed by read-back catch lost or reordered enables. A write and a read offered together catch wrong arbitration and a second transaction slipping in while one is still in flight.

// File: rtl/axreg_pkg.sv
package axreg_pkg;
    typedef enum logic [1:0] {C_IDLE, C_BUSY, C_RESP} cpu_state_t;
    typedef enum logic [1:0] {U_IDLE, U_WRITE, U_RDREQ, U_RDWAIT} usr_state_t;
    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/axreg_sync.sv
module axreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/axreg_cpu_side.sv
module axreg_cpu_side
    import axreg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   s_awaddr,
    input  logic            s_awvalid,
    output logic            s_awready,
    input  logic [DW-1:0]   s_wdata,
    input  logic [DW/8-1:0] s_wstrb,
    input  logic            s_wvalid,
    output logic            s_wready,
    output logic            s_bvalid,
    input  logic            s_bready,
    input  logic [AW-1:0]   s_araddr,
    input  logic            s_arvalid,
    output logic            s_arready,
    output logic [DW-1:0]   s_rdata,
    output logic            s_rvalid,
    input  logic            s_rready,
    input  logic            ack_sync,
    input  logic [DW-1:0]   rd_data_in,
    output logic            req_tgl,
    output logic            cap_write,
    output logic [AW-3:0]   cap_addr,
    output logic [DW-1:0]   cap_data,
    output logic [DW/8-1:0] cap_strb
);
    cpu_state_t state, state_nx;
    logic wr_go, rd_go, ack_match, retire;

    assign wr_go     = s_awvalid && s_wvalid;
    assign rd_go     = s_arvalid && !wr_go;
    assign ack_match = (ack_sync == req_tgl);
    assign retire    = cap_write ? s_bready : s_rready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= C_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            C_IDLE: if (wr_go || rd_go) state_nx = C_BUSY;
            C_BUSY: if (ack_match)      state_nx = C_RESP;
            C_RESP: if (retire)         state_nx = C_IDLE;
            default:                    state_nx = C_IDLE;
        endcase
    end

    always_comb begin
        s_awready = (state == C_IDLE) && wr_go;
        s_wready  = (state == C_IDLE) && wr_go;
        s_arready = (state == C_IDLE) && rd_go;
        s_bvalid  = (state == C_RESP) && cap_write;
        s_rvalid  = (state == C_RESP) && !cap_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl   <= 1'b0;
            cap_write <= 1'b0;
            cap_addr  <= '0;
            cap_data  <= '0;
            cap_strb  <= '0;
            s_rdata   <= '0;
        end else begin
            if (state == C_IDLE && wr_go) begin
                cap_write <= 1'b1;
                cap_addr  <= s_awaddr[AW-1:2];
                cap_data  <= s_wdata;
                cap_strb  <= s_wstrb;
                req_tgl   <= !req_tgl;
            end else if (state == C_IDLE && rd_go) begin
                cap_write <= 1'b0;
                cap_addr  <= s_araddr[AW-1:2];
                req_tgl   <= !req_tgl;
            end
            if (state == C_BUSY && ack_match && !cap_write)
                s_rdata <= rd_data_in;
        end
    end

    // R2
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awready |-> s_awaddr[1:0] == 2'b00) and (s_arready |-> s_araddr[1:0] == 2'b00));
    // R4
    aw_w_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_awready |-> (s_wvalid && s_wready));
    // R7
    one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awready || s_arready) |-> ack_match);
    // R8
    resp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_bvalid) || $rose(s_rvalid)) |-> ack_match);
    // R9
    bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);
    // R9
    rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
endmodule

// File: rtl/axreg_usr_side.sv
module axreg_usr_side
    import axreg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_sync,
    input  logic          is_write,
    input  logic          reg_rd_valid,
    input  logic [DW-1:0] reg_rd_data,
    output logic          reg_wr_en,
    output logic          reg_rd_req,
    output logic          rd_waiting,
    output logic          ack_tgl,
    output logic [DW-1:0] rd_hold
);
    usr_state_t state, state_nx;
    logic pending;

    assign pending = (req_sync != ack_tgl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= U_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            U_IDLE:   if (pending) state_nx = is_write ? U_WRITE : U_RDREQ;
            U_WRITE:  state_nx = U_IDLE;
            U_RDREQ:  state_nx = U_RDWAIT;
            U_RDWAIT: if (reg_rd_valid) state_nx = U_IDLE;
            default:  state_nx = U_IDLE;
        endcase
    end

    always_comb begin
        reg_wr_en  = (state == U_WRITE);
        reg_rd_req = (state == U_RDREQ);
        rd_waiting = (state == U_RDWAIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_tgl <= 1'b0;
            rd_hold <= '0;
        end else if (state == U_WRITE) begin
            ack_tgl <= !ack_tgl;
        end else if (state == U_RDWAIT && reg_rd_valid) begin
            rd_hold <= reg_rd_data;
            ack_tgl <= !ack_tgl;
        end
    end

    // R3
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_req |=> !reg_rd_req);
    // R8
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_tgl) |-> ($past(reg_wr_en) || $past(reg_rd_valid)));
endmodule

// File: rtl/axreg_bridge.sv
module axreg_bridge
    import axreg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic            cpu_clk,
    input  logic            cpu_rst_n,
    input  logic [AW-1:0]   s_awaddr,
    input  logic            s_awvalid,
    output logic            s_awready,
    input  logic [DW-1:0]   s_wdata,
    input  logic [DW/8-1:0] s_wstrb,
    input  logic            s_wvalid,
    output logic            s_wready,
    output logic [1:0]      s_bresp,
    output logic            s_bvalid,
    input  logic            s_bready,
    input  logic [AW-1:0]   s_araddr,
    input  logic            s_arvalid,
    output logic            s_arready,
    output logic [DW-1:0]   s_rdata,
    output logic [1:0]      s_rresp,
    output logic            s_rvalid,
    input  logic            s_rready,
    input  logic            usr_clk,
    input  logic            usr_rst_n,
    output logic [AW-3:0]   reg_addr,
    output logic            reg_wr_en,
    output logic [DW-1:0]   reg_wr_data,
    output logic [DW/8-1:0] reg_wr_be,
    output logic            reg_rd_req,
    input  logic [DW-1:0]   reg_rd_data,
    input  logic            reg_rd_valid
);
    logic          req_tgl, req_sync, ack_tgl, ack_sync;
    logic          cap_write, rd_waiting;
    logic [DW-1:0] rd_hold;

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

    axreg_cpu_side #(.AW(AW), .DW(DW)) u_cpu (
        .clk(cpu_clk), .rst_n(cpu_rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .ack_sync(ack_sync), .rd_data_in(rd_hold), .req_tgl(req_tgl),
        .cap_write(cap_write), .cap_addr(reg_addr),
        .cap_data(reg_wr_data), .cap_strb(reg_wr_be)
    );

    axreg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(usr_clk), .rst_n(usr_rst_n), .d(req_tgl), .q(req_sync)
    );

    axreg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_tgl), .q(ack_sync)
    );

    axreg_usr_side #(.DW(DW)) u_usr (
        .clk(usr_clk), .rst_n(usr_rst_n),
        .req_sync(req_sync), .is_write(cap_write),
        .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_rd_req(reg_rd_req),
        .rd_waiting(rd_waiting), .ack_tgl(ack_tgl), .rd_hold(rd_hold)
    );

    // R6
    rd_addr_hold_chk: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
        (reg_rd_req || (rd_waiting && !reg_rd_valid)) |=> $stable(reg_addr));
endmodule

// File: tb/sim_axreg_bridge.sv
module sim_axreg_bridge;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam logic [AW-1:0] BASE = 16'h0100;

    logic cpu_clk = 1'b0, usr_clk = 1'b0;
    logic cpu_rst_n = 1'b0, usr_rst_n = 1'b0;
    logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
    logic s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic s_bready = 1'b0, s_rready = 1'b0;
    logic [DW-1:0] s_wdata = '0;
    logic [SW-1:0] s_wstrb = '0;
    logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0] s_bresp, s_rresp;
    logic [DW-1:0] s_rdata;
    logic [AW-3:0] reg_addr;
    logic reg_wr_en, reg_rd_req;
    logic [DW-1:0] reg_wr_data;
    logic [SW-1:0] reg_wr_be;
    logic [DW-1:0] reg_rd_data = 32'hDEAD_BEEF;
    logic reg_rd_valid = 1'b0;

    always #5   cpu_clk = !cpu_clk;
    always #3.5 usr_clk = !usr_clk;

    axreg_bridge #(.AW(AW), .DW(DW)) u0 (.*);

    int errors = 0, checks = 0;
    int issued = 0, done = 0;
    int rd_lat = 1;
    bit inflight = 1'b0, finished = 1'b0;

    // reference model: bench-side register image and expected register-side ops
    logic [DW-1:0] model_mem [16];
    logic [DW-1:0] dev_mem   [16];
    bit            q_isw  [$];
    logic [AW-3:0] q_addr [$];
    logic [DW-1:0] q_data [$];
    logic [SW-1:0] q_strb [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [SW-1:0] be);
        logic [DW-1:0] r = old;
        for (int n = 0; n < SW; n++) if (be[n]) r[8*n +: 8] = nw[8*n +: 8];
        return r;
    endfunction

    // register target and per-clock comparison on the user side
    bit prev_wr = 1'b0, prev_rq = 1'b0, waiting = 1'b0;
    int lat_cnt = 0;
    logic [AW-3:0] hold_addr = '0;
    always @(negedge usr_clk) begin
        if (usr_rst_n) begin
            chk(!(prev_wr && reg_wr_en), "R3", "wr_en longer than one cycle", 1, 0);
            chk(!(prev_rq && reg_rd_req), "R5", "rd_req longer than one cycle", 1, 0);
            reg_rd_valid = 1'b0;
            reg_rd_data  = 32'hDEAD_BEEF;
            if (reg_wr_en) begin
                if (q_isw.size() == 0) chk(0, "R3", "unexpected write strobe", 1, 0);
                else begin
                    chk(q_isw[0] == 1'b1, "R3", "write strobe for a read", 0, 1);
                    chk(reg_addr == q_addr[0], "R2", "write word address", reg_addr, q_addr[0]);
                    chk(reg_wr_data == q_data[0], "R3", "write data", reg_wr_data, q_data[0]);
                    chk(reg_wr_be == q_strb[0], "R3", "byte enables", reg_wr_be, q_strb[0]);
                    dev_mem[reg_addr[3:0]] = merge(dev_mem[reg_addr[3:0]], reg_wr_data, reg_wr_be);
                    void'(q_isw.pop_front()); void'(q_addr.pop_front());
                    void'(q_data.pop_front()); void'(q_strb.pop_front());
                    done++;
                end
            end
            if (reg_rd_req) begin
                if (q_isw.size() == 0) chk(0, "R5", "unexpected read request", 1, 0);
                else begin
                    chk(q_isw[0] == 1'b0, "R5", "read request for a write", 1, 0);
                    chk(reg_addr == q_addr[0], "R2", "read word address", reg_addr, q_addr[0]);
                    void'(q_isw.pop_front()); void'(q_addr.pop_front());
                    void'(q_data.pop_front()); void'(q_strb.pop_front());
                end
                waiting = 1'b1; lat_cnt = rd_lat; hold_addr = reg_addr;
            end else if (waiting) begin
                chk(reg_addr == hold_addr, "R6", "address moved during read", reg_addr, hold_addr);
                lat_cnt--;
                if (lat_cnt == 0) begin
                    reg_rd_valid = 1'b1;
                    reg_rd_data  = dev_mem[hold_addr[3:0]];
                    waiting = 1'b0;
                    done++;
                end
            end
            prev_wr = reg_wr_en;
            prev_rq = reg_rd_req;
        end
    end

    // per-clock comparison on the CPU side
    always @(negedge cpu_clk) begin
        if (cpu_rst_n) begin
            if (inflight)
                chk(!s_awready && !s_wready && !s_arready, "R7", "ready while busy",
                    {s_awready, s_wready, s_arready}, 0);
            if (s_bvalid || s_rvalid)
                chk(done == issued, "R8", "response before register access", done, issued);
            if (s_bvalid) chk(s_bresp == 2'b00, "R8", "bresp", s_bresp, 0);
            if (s_rvalid) chk(s_rresp == 2'b00, "R8", "rresp", s_rresp, 0);
        end
    end

    task automatic wait_resp(input bit is_wr, input logic [DW-1:0] exp, input int delay);
        do @(negedge cpu_clk); while (!(is_wr ? s_bvalid : s_rvalid));
        if (!is_wr) chk(s_rdata == exp, "R5", "read data", s_rdata, exp);
        for (int i = 0; i < delay; i++) begin
            @(negedge cpu_clk);
            chk(is_wr ? s_bvalid : s_rvalid, "R9", "response dropped before ready", 0, 1);
            if (!is_wr) chk(s_rdata == exp, "R9", "rdata not stable", s_rdata, exp);
        end
        if (is_wr) s_bready = 1'b1; else s_rready = 1'b1;
        @(posedge cpu_clk); #1;
        s_bready = 1'b0; s_rready = 1'b0; inflight = 1'b0;
    endtask

    task automatic push_write(input int idx, input logic [DW-1:0] d, input logic [SW-1:0] be);
        q_isw.push_back(1'b1); q_addr.push_back((BASE >> 2) + idx[AW-3:0]);
        q_data.push_back(d); q_strb.push_back(be);
        model_mem[idx] = merge(model_mem[idx], d, be);
    endtask

    task automatic push_read(input int idx);
        q_isw.push_back(1'b0); q_addr.push_back((BASE >> 2) + idx[AW-3:0]);
        q_data.push_back('0); q_strb.push_back('0);
    endtask

    task automatic axi_write(input int idx, input logic [DW-1:0] d, input logic [SW-1:0] be,
                             input int w_delay, input int b_delay);
        @(negedge cpu_clk);
        s_awaddr = BASE + AW'(idx * 4); s_awvalid = 1'b1;
        for (int i = 0; i < w_delay; i++) begin
            #1 chk(!s_awready && !s_wready, "R4", "accepted address without data",
                   {s_awready, s_wready}, 0);
            @(negedge cpu_clk);
        end
        s_wdata = d; s_wstrb = be; s_wvalid = 1'b1;
        push_write(idx, d, be);
        #1;
        while (!s_awready) begin @(negedge cpu_clk); #1; end
        chk(s_wready, "R4", "wready not with awready", s_wready, 1);
        @(posedge cpu_clk); #1;
        issued++; inflight = 1'b1;
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        wait_resp(1'b1, '0, b_delay);
    endtask

    task automatic axi_read(input int idx, input int lat, input int r_delay);
        rd_lat = lat;
        @(negedge cpu_clk);
        s_araddr = BASE + AW'(idx * 4); s_arvalid = 1'b1;
        push_read(idx);
        #1;
        while (!s_arready) begin @(negedge cpu_clk); #1; end
        @(posedge cpu_clk); #1;
        issued++; inflight = 1'b1;
        s_arvalid = 1'b0;
        wait_resp(1'b0, model_mem[idx], r_delay);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        chk(0, "R7", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin model_mem[i] = '0; dev_mem[i] = '0; end
        repeat (4) @(negedge cpu_clk);
        cpu_rst_n = 1'b1; usr_rst_n = 1'b1;
        repeat (3) @(negedge cpu_clk);
        // R1: idle outputs after reset
        chk(!s_awready && !s_wready && !s_arready && !s_bvalid && !s_rvalid, "R1",
            "cpu-side outputs after reset", {s_awready, s_wready, s_arready, s_bvalid, s_rvalid}, 0);
        chk(!reg_wr_en && !reg_rd_req, "R1", "register strobes after reset",
            {reg_wr_en, reg_rd_req}, 0);

        axi_write(0, 32'h1234_5678, 4'hF, 0, 0);                // R3
        axi_read(0, 1, 0);                                      // R5
        axi_write(1, 32'hCAFE_F00D, 4'hF, 3, 4);                // R4, R9
        axi_read(1, 4, 3);                                      // R6, R9
        axi_write(0, 32'hAABB_CCDD, 4'b0101, 0, 0);             // R3 partial
        axi_read(0, 2, 0);
        axi_write(0, 32'h1122_3344, 4'b1010, 1, 1);
        axi_write(0, 32'hFFFF_FFFF, 4'b0000, 0, 0);             // R3 no byte enabled
        axi_read(0, 3, 1);
        axi_write(5, 32'h0505_0505, 4'hF, 0, 0);                // R2 distinct words
        axi_write(6, 32'h0606_0606, 4'hF, 0, 0);
        axi_read(5, 1, 0);
        axi_read(6, 2, 0);

        // R10: write and read offered together
        @(negedge cpu_clk);
        s_awaddr = BASE + 16'd8; s_wdata = 32'h7777_0002; s_wstrb = 4'hF;
        s_araddr = BASE + 16'd8;
        s_awvalid = 1'b1; s_wvalid = 1'b1; s_arvalid = 1'b1;
        push_write(2, 32'h7777_0002, 4'hF);
        push_read(2);
        #1;
        chk(s_awready && !s_arready, "R10", "write not preferred", {s_awready, s_arready}, 2'b10);
        @(posedge cpu_clk); #1;
        issued++; inflight = 1'b1;
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        rd_lat = 2;
        wait_resp(1'b1, '0, 2);
        #1;
        while (!s_arready) begin @(negedge cpu_clk); #1; end
        @(posedge cpu_clk); #1;
        issued++; inflight = 1'b1;
        s_arvalid = 1'b0;
        wait_resp(1'b0, model_mem[2], 0);

        for (int k = 0; k < 8; k++) begin
            axi_write(8 + k, {k[7:0], 8'hA5, ~k[7:0], 8'h3C}, 4'(k * 3 + 1), k % 3, k % 2);
            axi_read(8 + k, 1 + (k % 4), k % 3);
        end

        repeat (10) @(negedge cpu_clk);
        chk(q_isw.size() == 0, "R3", "register ops left unserved", q_isw.size(), 0);
        summary();
    end
endmodule